// File: doc/BRIEF.md
# T1 Transmit Superframe Framing Generator

This block produces the serial bit stream that goes out on a 1.544 Mbit/s T1 line, one bit per cycle of the transmit clock. Each 193-bit frame opens with a single framing bit and then carries 24 eight-bit channel bytes. The block fetches these bytes through a parallel load strobe and sends each one most significant bit first. The framing bits across successive frames form one of two superframe formats, chosen at run time. The short format is twelve frames long and carries fixed terminal and signalling alignment patterns. The extended format is twenty-four frames long and shares its framing-bit slots among three things: a fixed alignment pattern, a CRC-6 check over the previous superframe, and a serial data link.

The data link is fed by a slow serial input. The block produces a data-link clock that rises once in the frame before each odd frame, and it captures one link bit per rising edge of that clock. With the superframe input held high, the frame counter runs freely. A high-to-low transition on that input makes the next frame frame 1, which lets an outside timing source align the superframe. Line coding, signalling insertion, rate conversion and elastic buffering all happen outside this block.

Top module: `t1_sf_tx`

## Requirements
- R1: A frame is 193 clock cycles. `fbit_slot` is high exactly in the first cycle of each frame, and `line_bit` carries the framing bit in that cycle.
- R2: `chan_load` is high in the framing-bit cycle and in the last bit cycle of channels 1 to 23. In those cycles, `chan_idx` (0 to 23) names the channel whose byte is taken from `chan_byte` at the closing clock edge. That byte then appears on `line_bit` over the next 8 cycles, bit 7 first.
- R3: `frame_num` (1-based) advances at each frame boundary. It returns to 1 after frame 12 when `esf_mode`=0 and after frame 24 when `esf_mode`=1.
- R4: With `esf_mode`=0, frames 1,3,5,7,9,11 carry framing bits 1,0,1,0,1,0 and frames 2,4,6,8,10,12 carry 0,0,1,1,1,0.
- R5: With `esf_mode`=1, frames 4,8,12,16,20,24 carry framing bits 0,0,1,0,1,1.
- R6: With `esf_mode`=1, frames 2,6,10,14,18,22 carry CRC bits C1..C6 (C1 = register bit 5). The CRC uses the generator x^6+x+1 with the register starting at zero. It covers every line bit sent since the previous start of frame 1, with framing bits counted as 1. Before the first such span has finished after reset, these bits are zero.
- R7: With `esf_mode`=1, odd frames carry the most recently captured data-link bit as their framing bit. That bit is 0 after reset.
- R8: `dl_clk` is high during bit cycles 97 to 192 of even-numbered frames when `esf_mode`=1, and low otherwise. `dl_bit` is captured at the clock edge that ends bit cycle 97.
- R9: When `sf_pulse_n` is sampled high at one edge and low at the next, the current frame completes unchanged and the next frame is frame 1. This includes a fall sampled at a frame's closing edge. The CRC span restarts at that frame.
- R10: Holding `sf_pulse_n` high, or holding it low after a fall, causes no further realignment: frames keep counting freely.
- R11: While `rst_n` is low, the block sits at bit cycle 0 of frame 1 with an empty data-link bit and a zero CRC. In the short format, `line_bit` is therefore 1 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1.544 MHz transmit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| esf_mode | input | 1 | 1 selects the 24-frame extended format, 0 the 12-frame format |
| sf_pulse_n | input | 1 | Low-going superframe alignment input |
| chan_byte | input | 8 | Channel byte, sampled when `chan_load` is high |
| dl_bit | input | 1 | Serial data-link input |
| line_bit | output | 1 | Outgoing line bit |
| fbit_slot | output | 1 | High during the framing-bit cycle |
| frame_num | output | 5 | Current frame number within the superframe, from 1 |
| chan_load | output | 1 | Channel byte load strobe |
| chan_idx | output | 5 | Channel being loaded, 0 to 23 |
| dl_clk | output | 1 | Generated data-link clock |

## Verification
The assertions assume that `esf_mode` changes only in the framing-bit cycle of frame 1, so the data-link clock window and the frame count are never disturbed partway through a frame. The stimulus follows this rule: it switches modes only when its own model sits at bit 0 of frame 1. All other inputs are random each cycle. Superframe pulses are mostly single-cycle random falls. On top of these come directed cases: a fall timed exactly at a frame's closing edge, a two-cycle pulse in mid-frame, and a long low hold. These exercise realignment and its restart of the CRC span.

// File: rtl/t1_sf_tx.sv
module t1_sf_tx #(
  parameter int NCH = 24,
  parameter int CW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          esf_mode,
  input  logic          sf_pulse_n,
  input  logic [CW-1:0] chan_byte,
  input  logic          dl_bit,
  output logic          line_bit,
  output logic          fbit_slot,
  output logic [4:0]    frame_num,
  output logic          chan_load,
  output logic [4:0]    chan_idx,
  output logic          dl_clk
);
  localparam int FBITS = NCH * CW + 1;
  localparam int BW    = $clog2(FBITS);
  localparam int LAST  = FBITS - 1;
  localparam int DLPOS = LAST / 2 + 1;
  localparam logic [7:0] SIG_PAT = 8'b0001_1100;
  localparam logic [7:0] ALN_PAT = 8'b0011_0100;

  logic [BW-1:0] bit_cnt;
  logic [4:0]    idx;
  logic [CW-1:0] sh;
  logic [5:0]    crc, crc_prev, crc_nx;
  logic          dl_q, pend_q, sf_q, fbit;

  wire       at_end  = bit_cnt == BW'(LAST);
  wire       sf_fall = sf_q & ~sf_pulse_n;
  wire [4:0] sf_last = esf_mode ? 5'd23 : 5'd11;
  wire       wrap    = pend_q | sf_fall | (idx >= sf_last);
  wire [2:0] half    = idx[3:1];
  wire [2:0] quarter = idx[4:2];
  wire       crc_in  = fbit_slot | sh[CW-1];

  assign fbit_slot = bit_cnt == '0;
  assign frame_num = idx + 5'd1;
  assign chan_load = (bit_cnt % BW'(CW) == '0) && !at_end;
  assign chan_idx  = 5'(bit_cnt / BW'(CW));
  assign dl_clk    = esf_mode & idx[0] & (bit_cnt >= BW'(DLPOS));
  assign line_bit  = fbit_slot ? fbit : sh[CW-1];
  assign crc_nx    = {crc[4:0], 1'b0} ^ ({6{crc[5] ^ crc_in}} & 6'b000011);

  always_comb begin
    if (!esf_mode)
      fbit = idx[0] ? SIG_PAT[half] : ~idx[1];
    else if (!idx[0])
      fbit = dl_q;
    else if (idx[1])
      fbit = ALN_PAT[quarter];
    else
      fbit = crc_prev[3'd5 - quarter];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      idx      <= '0;
      sh       <= '0;
      crc      <= '0;
      crc_prev <= '0;
      dl_q     <= 1'b0;
      pend_q   <= 1'b0;
      sf_q     <= 1'b1;
    end else begin
      sf_q <= sf_pulse_n;
      sh   <= chan_load ? chan_byte : sh << 1;
      if (dl_clk && bit_cnt == BW'(DLPOS)) dl_q <= dl_bit;
      if (at_end) begin
        bit_cnt <= '0;
        pend_q  <= 1'b0;
        if (wrap) begin
          idx      <= '0;
          crc      <= '0;
          crc_prev <= crc_nx;
        end else begin
          idx <= idx + 5'd1;
          crc <= crc_nx;
        end
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
        crc     <= crc_nx;
        pend_q  <= pend_q | sf_fall;
      end
    end
  end

  a_r1_slot_single: assert property (@(posedge clk) disable iff (!rst_n)
    fbit_slot |=> !fbit_slot);
  a_r2_load_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    fbit_slot |-> (chan_load && chan_idx == 5'd0));
  a_r3_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_num >= 5'd1 && frame_num <= 5'd24));
  a_r9_realign: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(at_end) && $past(pend_q)) |-> frame_num == 5'd1);
  a_r8_dl_window: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_clk && !at_end) |=> dl_clk);
  a_r8_dl_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_clk && at_end) |=> !dl_clk);
endmodule

// File: tb/t1_sf_tx_bench.sv
`timescale 1ns/1ps
module t1_sf_tx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic esf_mode = 1'b0;
  logic sf_pulse_n = 1'b1;
  logic [7:0] chan_byte = '0;
  logic dl_bit = 1'b0;
  logic line_bit, fbit_slot, chan_load, dl_clk;
  logic [4:0] frame_num, chan_idx;

  always #2 clk = ~clk;

  t1_sf_tx u_t1_sf_tx (
    .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .sf_pulse_n(sf_pulse_n),
    .chan_byte(chan_byte), .dl_bit(dl_bit), .line_bit(line_bit),
    .fbit_slot(fbit_slot), .frame_num(frame_num), .chan_load(chan_load),
    .chan_idx(chan_idx), .dl_clk(dl_clk)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  int m_bit = 0, m_idx = 0;
  bit m_pend = 0, m_prevn = 1, m_dl = 0, m_forced = 0, edge_done = 0;
  logic [7:0] m_byte = '0;
  logic [5:0] m_crc = '0, m_crc_last = '0;
  int ft[6]  = '{1, 0, 1, 0, 1, 0};
  int fs[6]  = '{0, 0, 1, 1, 1, 0};
  int fps[6] = '{0, 0, 1, 0, 1, 1};

  function automatic logic [5:0] crc_step(input logic [5:0] c, input logic d);
    logic [6:0] r;
    r = {c, 1'b0};
    if (c[5] ^ d) r = r ^ 7'b1000011;
    return r[5:0];
  endfunction

  function automatic logic exp_fbit(input bit esf);
    if (!esf) return (m_idx % 2 == 0) ? 1'(ft[m_idx/2]) : 1'(fs[m_idx/2]);
    if (m_idx % 2 == 0) return m_dl;
    if (m_idx % 4 == 1) return m_crc_last[5 - m_idx/4];
    return 1'(fps[m_idx/4]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (frame %0d bit %0d)", req, act, exp, m_idx + 1, m_bit);
    end
  endtask

  function automatic logic exp_line();
    if (m_bit == 0) return exp_fbit(esf_mode);
    return m_byte[7 - ((m_bit - 1) % 8)];
  endfunction

  task automatic check_all(input int cyc);
    string t;
    if (m_bit != 0) t = "R2";
    else if (!esf_mode) t = "R4";
    else if (m_idx % 2 == 0) t = "R7";
    else if (m_idx % 4 == 1) t = "R6";
    else t = "R5";
    check(t, line_bit, exp_line());
    check("R1", fbit_slot, m_bit == 0);
    if (m_forced) check("R9", frame_num, m_idx + 1);
    else if (cyc >= 30000 && cyc < 31200) check("R10", frame_num, m_idx + 1);
    else check("R3", frame_num, m_idx + 1);
    check("R2", chan_load, (m_bit % 8 == 0) && m_bit != 192);
    if (chan_load) check("R2", chan_idx, m_bit / 8);
    check("R8", dl_clk, esf_mode && (m_idx % 2 == 1) && m_bit >= 97);
  endtask

  task automatic step();
    logic e, fall;
    logic [5:0] cn;
    e = exp_line();
    cn = crc_step(m_crc, (m_bit == 0) ? 1'b1 : e);
    fall = m_prevn && !sf_pulse_n;
    m_prevn = sf_pulse_n;
    if (esf_mode && (m_idx % 2 == 1) && m_bit == 97) m_dl = dl_bit;
    if ((m_bit % 8 == 0) && m_bit != 192) m_byte = chan_byte;
    if (m_bit == 192) begin
      m_bit = 0;
      m_forced = (m_pend || fall);
      if (m_pend || fall || m_idx >= (esf_mode ? 23 : 11)) begin
        m_idx = 0; m_crc_last = cn; m_crc = '0;
      end else begin
        m_idx++; m_crc = cn;
      end
      m_pend = 0;
    end else begin
      m_bit++; m_crc = cn; m_pend = m_pend | fall;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11", fbit_slot, 1);
    check("R11", frame_num, 1);
    check("R11", line_bit, 1);
    check("R11", dl_clk, 0);
    rst_n = 1'b1;
    step();
    for (int cyc = 1; cyc < 60000; cyc++) begin
      @(negedge clk);
      check_all(cyc);
      if (m_bit == 0 && m_idx == 0)
        esf_mode = !(cyc < 5000 || (cyc >= 40000 && cyc < 47000));
      sf_pulse_n = 1'b1;
      if (cyc >= 20000 && !edge_done && m_bit == 192) begin
        sf_pulse_n = 1'b0; edge_done = 1;
      end
      if (cyc >= 25000 && cyc < 25002) sf_pulse_n = 1'b0;
      if (cyc >= 30000 && cyc < 30600) sf_pulse_n = 1'b0;
      if ($urandom % 6000 == 0) sf_pulse_n = 1'b0;
      dl_bit = 1'($urandom);
      chan_byte = 8'($urandom);
      step();
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule